// File: doc/BRIEF.md
# Mode-Selectable Serial Shift Unit

This block is a byte-wide serial shifter for a peripheral adapter. Software reaches it through a four-register bus: a shift data register, a control register, an interrupt flag register and an interrupt enable register. A 3-bit mode field in the control register chooses the direction and the clock source.

In transmit mode the unit drives the clock pin and the data pin itself, at one clock-pin phase per system clock cycle. A transfer starts when software writes the data register. In receive mode an external device supplies clock pulses on the clock pin, and the unit takes one data bit on each rising edge, after a two-flop synchronizer. After eight bits the unit sets a completion flag. It can also raise an interrupt request.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset all four registers read 0x00, `irq` is low, `sclk_out` is high, and `sclk_oe` and `sdat_oe` are low.
- R2: The mode is held in bits 4:2 of the control register (address 1), which reads back as written. Mode 3'b110 is transmit and mode 3'b011 is receive. `sclk_oe` and `sdat_oe` are high only in transmit mode.
- R3: In transmit mode, a write to the data register (address 0) sends the byte MSB first over eight clock-pin periods. Each period is one cycle low followed by one cycle high. `sdat_out` changes only while `sclk_out` is low.
- R4: After the eighth period `sclk_out` stays high, and flag bit 2 (mask 0x04) of the flag register (address 2) sets. The data register then reads back the byte that was sent.
- R5: In receive mode, each synchronized rising edge on `sclk_in` shifts `sdat_in` into the data register, MSB first. The eighth edge sets flag bit 2. Further edges leave the data register unchanged until it is accessed.
- R6: A read or write of the data register, or a write of the control register, clears flag bit 2 and restarts the 3-bit bit counter.
- R7: In any mode other than transmit, a synchronized rising edge on `sclk_in` sets flag bit 4 (mask 0x10). In transmit mode such edges have no effect on the flags.
- R8: Writing the flag register clears each flag whose written bit is 1 and leaves the others unchanged.
- R9: Writing the enable register (address 3) with bit 7 = 1 sets the enables selected by bits 6:0. With bit 7 = 0 it clears them. The enable register reads back bit 7 as 0.
- R10: `irq` goes high one cycle after any flag is set whose enable is set, and it reads as bit 7 of the flag register.
- R11: A read returns its data on `reg_rdata` in the cycle after `reg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 flags, 3 enables |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sclk_in | input | 1 | Clock pin as received (asynchronous) |
| sdat_in | input | 1 | Data pin as received (asynchronous) |
| sclk_out | output | 1 | Clock pin drive value |
| sclk_oe | output | 1 | Clock pin output enable |
| sdat_out | output | 1 | Data pin drive value |
| sdat_oe | output | 1 | Data pin output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The clock-phase and data-timing properties assume that software does not rewrite the data register in the middle of a transmission. The bench waits out every transfer before it touches that register again. In receive mode the properties and the scoreboard assume that `sdat_in` is stable for several cycles around each rising edge of `sclk_in`. They also assume that each level of `sclk_in` lasts longer than the synchronizer delay. The bench drives each level for three cycles and changes data only while the clock pin is low. The scoreboard rebuilds transmitted bytes at the pins and predicts every register read from the requirements alone.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int REG_W = 8;
  localparam int CNT_W = $clog2(REG_W);
  localparam int FLAG_W = REG_W - 1;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
  localparam logic [1:0] ADDR_ENAB = 2'd3;

  localparam int MODE_LSB = 2;
  localparam logic [2:0] MODE_IN_EXT  = 3'b011;
  localparam logic [2:0] MODE_OUT_SYS = 3'b110;

  localparam int FLAG_DONE = 2;
  localparam int FLAG_EDGE = 4;
endpackage

// File: rtl/sru_sync.sv
module sru_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= INIT;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= INIT;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sru_core.sv
module sru_core
  import sru_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             sr_load,
  input  logic             sr_touch,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] load_data,
  input  logic             clk_s,
  input  logic             din_s,
  output logic [REG_W-1:0] sr_q,
  output logic             sclk_q,
  output logic             sdat_q,
  output logic             done_set,
  output logic             edge_set
);
  logic             clk_prev;
  logic             rise;
  logic             active;
  logic             in_full;
  logic [CNT_W-1:0] bitcnt;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  assign rise     = clk_s & ~clk_prev;
  assign edge_set = rise && (mode != MODE_OUT_SYS);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b1;
      sr_q     <= '0;
      sclk_q   <= 1'b1;
      sdat_q   <= 1'b1;
      active   <= 1'b0;
      in_full  <= 1'b0;
      bitcnt   <= '0;
      done_set <= 1'b0;
    end else begin
      clk_prev <= clk_s;
      done_set <= 1'b0;
      if (sr_touch || ctrl_wr) begin
        bitcnt  <= '0;
        in_full <= 1'b0;
      end
      if (sr_load) begin
        if (mode == MODE_OUT_SYS) begin
          sr_q   <= {load_data[REG_W-2:0], load_data[REG_W-1]};
          sdat_q <= load_data[REG_W-1];
          sclk_q <= 1'b0;
          active <= 1'b1;
        end else begin
          sr_q <= load_data;
        end
      end else begin
        case (mode)
          MODE_OUT_SYS: begin
            if (active) begin
              sclk_q <= ~sclk_q;
              if (sclk_q) begin
                sdat_q <= sr_q[REG_W-1];
                sr_q   <= {sr_q[REG_W-2:0], sr_q[REG_W-1]};
                bitcnt <= bitcnt + 1'b1;
              end else if (bitcnt == LAST) begin
                active   <= 1'b0;
                done_set <= 1'b1;
              end
            end
          end
          MODE_IN_EXT: begin
            active <= 1'b0;
            sclk_q <= 1'b1;
            if (rise && !in_full && !sr_touch && !ctrl_wr) begin
              sr_q   <= {sr_q[REG_W-2:0], din_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST) begin
                in_full  <= 1'b1;
                done_set <= 1'b1;
              end
            end
          end
          default: begin
            active <= 1'b0;
            sclk_q <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sru_intc.sv
module sru_intc
  import sru_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_flag,
  input  logic              wr_enab,
  input  logic [REG_W-1:0]  wdata,
  input  logic              done_set,
  input  logic              done_clr,
  input  logic              edge_set,
  output logic [FLAG_W-1:0] flag_q,
  output logic [FLAG_W-1:0] en_q,
  output logic              irq_q
);
  logic [FLAG_W-1:0] flag_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_flag)  flag_d = flag_d & ~wdata[FLAG_W-1:0];
    if (done_clr) flag_d[FLAG_DONE] = 1'b0;
    if (done_set) flag_d[FLAG_DONE] = 1'b1;
    if (edge_set) flag_d[FLAG_EDGE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_enab) begin
        if (wdata[REG_W-1]) en_q <= en_q | wdata[FLAG_W-1:0];
        else                en_q <= en_q & ~wdata[FLAG_W-1:0];
      end
      irq_q <= |(flag_q & en_q);
    end
  end
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import sru_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sclk_in,
  input  logic             sdat_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             sdat_out,
  output logic             sdat_oe,
  output logic             irq
);
  logic [REG_W-1:0]  ctrl_q;
  logic [2:0]        mode;
  logic [1:0]        pins_s;
  logic [REG_W-1:0]  sr_w;
  logic [FLAG_W-1:0] flag_w;
  logic [FLAG_W-1:0] en_w;
  logic              done_set, edge_set;
  logic              sr_wr, sr_rd, ctrl_wr;

  assign sr_wr   = reg_wr && (reg_addr == ADDR_DATA);
  assign sr_rd   = reg_rd && (reg_addr == ADDR_DATA);
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign mode    = ctrl_q[MODE_LSB +: 3];

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata;
  end

  sru_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({sclk_in, sdat_in}), .q(pins_s)
  );

  sru_core u_core (
    .clk(clk), .rst(rst), .mode(mode),
    .sr_load(sr_wr), .sr_touch(sr_wr || sr_rd), .ctrl_wr(ctrl_wr),
    .load_data(reg_wdata), .clk_s(pins_s[1]), .din_s(pins_s[0]),
    .sr_q(sr_w), .sclk_q(sclk_out), .sdat_q(sdat_out),
    .done_set(done_set), .edge_set(edge_set)
  );

  sru_intc u_intc (
    .clk(clk), .rst(rst),
    .wr_flag(reg_wr && (reg_addr == ADDR_FLAG)),
    .wr_enab(reg_wr && (reg_addr == ADDR_ENAB)),
    .wdata(reg_wdata), .done_set(done_set),
    .done_clr(sr_wr || sr_rd || ctrl_wr), .edge_set(edge_set),
    .flag_q(flag_w), .en_q(en_w), .irq_q(irq)
  );

  assign sclk_oe = (mode == MODE_OUT_SYS);
  assign sdat_oe = (mode == MODE_OUT_SYS);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_DATA: reg_rdata <= sr_w;
        ADDR_CTRL: reg_rdata <= ctrl_q;
        ADDR_FLAG: reg_rdata <= {irq, flag_w};
        default:   reg_rdata <= {1'b0, en_w};
      endcase
    end
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker
  import sru_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              sclk_out,
  input logic              sclk_oe,
  input logic              sdat_out,
  input logic              sdat_oe,
  input logic              irq,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] en
);
  logic sr_wr;
  assign sr_wr = reg_wr && (reg_addr == ADDR_DATA);

  a_r3_low_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && !sclk_out && !sr_wr) |=> sclk_out);

  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (sdat_oe && $past(sdat_oe) && (sdat_out != $past(sdat_out))) |-> !sclk_out);

  a_r4_done_clock_high: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags[FLAG_DONE]) && sclk_oe && !$past(sr_wr)) |-> sclk_out);

  a_r9_enable_set: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_ENAB && reg_wdata[REG_W-1])
      |=> ((en & $past(reg_wdata[FLAG_W-1:0])) == $past(reg_wdata[FLAG_W-1:0])));

  a_r9_enable_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_ENAB && !reg_wdata[REG_W-1])
      |=> ((en & $past(reg_wdata[FLAG_W-1:0])) == '0));

  a_r10_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(flags & en)) |=> irq);

  a_r10_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & en)) |=> !irq);
endmodule

bind serial_shift_unit sru_checker u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
  .sdat_out(sdat_out), .sdat_oe(sdat_oe), .irq(irq),
  .flags(flag_w), .en(en_w)
);

// File: tb/tb_serial_shift_unit.sv
module tb_serial_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sclk_in = 1'b1, sdat_in = 1'b1;
  logic       sclk_out, sclk_oe, sdat_out, sdat_oe, irq;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t rdq[$];
  exp_t outq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shift_unit dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_in(sclk_in), .sdat_in(sdat_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdat_out(sdat_out), .sdat_oe(sdat_oe),
    .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rdq.push_back('{exp, req});
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_out(input logic [7:0] b);
    outq.push_back('{b, "R3 serial byte"});
    bus_wr(2'd0, b);
    repeat (20) @(negedge clk);
  endtask

  task automatic send_in(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sdat_in = b[i]; sclk_in = 1'b0;
      repeat (3) @(negedge clk);
      sclk_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_clk();
    @(negedge clk); sclk_in = 1'b0;
    repeat (4) @(negedge clk); sclk_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // read monitor: pops the expected value one cycle after the read strobe (R11)
  logic rd_v = 1'b0;
  always @(posedge clk) rd_v <= reg_rd;
  always @(negedge clk) begin
    if (rd_v) begin
      if (rdq.size() > 0) begin
        exp_t e;
        e = rdq.pop_front();
        check({e.req, " R11"}, reg_rdata, e.val);
      end else begin
        check("R11 unexpected read", reg_rdata, 8'h00);
      end
    end
  end

  // serial monitor: rebuilds bytes from the pins at rising clock-pin edges
  logic       prev_sclk = 1'b1;
  logic [7:0] shacc = '0;
  int         nbits = 0;
  always @(negedge clk) begin
    if (sclk_oe && !prev_sclk && sclk_out) begin
      shacc = {shacc[6:0], sdat_out};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (outq.size() > 0) begin
          exp_t e;
          e = outq.pop_front();
          check(e.req, shacc, e.val);
        end else begin
          check("R3 unexpected byte", shacc, 8'hxx);
        end
      end
    end
    prev_sclk = sclk_out;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 sclk_out", {7'b0, sclk_out}, 8'h01);
    check("R1 oe", {6'b0, sclk_oe, sdat_oe}, 8'h00);
    bus_rd(2'd0, 8'h00, "R1 data");
    bus_rd(2'd1, 8'h00, "R1 ctrl");
    bus_rd(2'd2, 8'h00, "R1 flags");
    bus_rd(2'd3, 8'h00, "R1 enables");

    // R2 transmit mode
    bus_wr(2'd1, 8'h18);
    bus_rd(2'd1, 8'h18, "R2 ctrl readback");
    check("R2 oe in transmit", {6'b0, sclk_oe, sdat_oe}, 8'h03);

    // R3/R4 transmit
    send_out(8'hA5);
    send_out(8'h3C);
    bus_rd(2'd2, 8'h04, "R4 done flag");
    check("R4 clock idles high", {7'b0, sclk_out}, 8'h01);
    bus_rd(2'd0, 8'h3C, "R4 data readback");
    bus_rd(2'd2, 8'h00, "R6 read clears done");

    // R10 interrupt path
    send_out(8'h81);
    bus_wr(2'd3, 8'h84);
    repeat (2) @(negedge clk);
    check("R10 irq asserted", {7'b0, irq}, 8'h01);
    bus_rd(2'd3, 8'h04, "R9 enable set");
    bus_rd(2'd2, 8'h84, "R10 irq in flag bit7");
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd2, 8'h84, "R8 zero writes keep flag");
    bus_wr(2'd2, 8'h04);
    repeat (2) @(negedge clk);
    check("R8 irq drops after clear", {7'b0, irq}, 8'h00);
    bus_rd(2'd2, 8'h00, "R8 flag cleared");
    bus_wr(2'd3, 8'h7F);
    bus_rd(2'd3, 8'h00, "R9 enable clear all");

    // R5 receive
    bus_wr(2'd1, 8'h0C);
    check("R2 oe off in receive", {6'b0, sclk_oe, sdat_oe}, 8'h00);
    send_in(8'h5A);
    bus_rd(2'd2, 8'h14, "R5 done and edge flags");
    bus_rd(2'd0, 8'h5A, "R5 received byte");
    bus_rd(2'd2, 8'h10, "R6 data read clears done");
    bus_wr(2'd2, 8'h10);
    bus_rd(2'd2, 8'h00, "R8 edge flag cleared");
    send_in(8'hC3);
    send_in(8'h0F);
    bus_rd(2'd0, 8'hC3, "R5 extra edges ignored");
    send_in(8'h96);
    bus_rd(2'd0, 8'h96, "R6 counter restarted");

    // R7 edge flag in idle mode, not in transmit mode
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd2, 8'h00, "R8 clear all");
    pulse_clk();
    bus_rd(2'd2, 8'h10, "R7 edge flag in idle mode");
    bus_rd(2'd0, 8'h96, "R7 idle mode no shift");
    bus_wr(2'd1, 8'h18);
    bus_wr(2'd2, 8'hFF);
    pulse_clk();
    bus_rd(2'd2, 8'h00, "R7 no edge flag in transmit");

    // R9/R10 selective enable
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd3, 8'h90);
    bus_rd(2'd3, 8'h10, "R9 set edge enable");
    check("R10 irq low before edge", {7'b0, irq}, 8'h00);
    pulse_clk();
    check("R10 irq on enabled edge flag", {7'b0, irq}, 8'h01);
    bus_wr(2'd3, 8'h10);
    repeat (2) @(negedge clk);
    check("R9 clear enable drops irq", {7'b0, irq}, 8'h00);

    repeat (4) @(negedge clk);
    if (outq.size() != 0) check("R3 bytes not seen", 8'(outq.size()), 8'h00);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule